// File: doc/BRIEF.md
# 2x2 Byte Matrix Multiply-Accumulate

This datapath block takes two 128-bit operands made of bytes. It reads the first operand as a matrix of 2 rows by 8 columns. It reads the second as a matrix of 8 rows by 2 columns, stored one column after the other. The block multiplies the two matrices. The 2x2 product has 32-bit elements, and each element is added to one of four 32-bit accumulator lanes supplied on a 128-bit input. The four sums come out on a registered 128-bit output and replace the old accumulator values in the caller's register file.

Each output lane is an eight-term dot product plus its accumulator. The term comes from one row of the first matrix and one column of the second. A 2-bit mode input sets how each operand's bytes are read. Both operands can be signed, both can be unsigned, or the first can be unsigned while the second is signed. A new operation may be issued on every clock. The result appears one clock after the issue, flagged by a valid output.

Top module: `byte_mmla2x2`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, valid_out is 0 and acc_out is all zeros.
- R2: valid_out is high in exactly the cycles that follow a clock edge where valid_in was high.
- R3: Row r of the first matrix is byte lanes 8r..8r+7 of src_a, where byte k sits at bits [8k+7:8k]. Column c of the second matrix is byte lanes 8c..8c+7 of src_b. The result for row r and column c uses accumulator lane 2r+c and is placed in that lane, which occupies bits [32(2r+c)+31 : 32(2r+c)] of acc_in and of acc_out.
- R4: With mode 2'b00, the bytes of both operands are read as two's-complement signed values.
- R5: With mode 2'b01, the bytes of both operands are read as unsigned values.
- R6: With mode 2'b10, the bytes of src_a are read as unsigned and the bytes of src_b as signed.
- R7: Mode 2'b11 is reserved and gives the same results as mode 2'b00.
- R8: Each lane sum wraps modulo 2^32, with no saturation or overflow flag.
- R9: acc_out holds its value across every clock edge where valid_in is low.
- R10: Operations issued on consecutive clocks, each with its own mode and operands, each produce their own correct result in the cycle after their own issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Issues an operation this cycle |
| mode | input | 2 | Operand signedness: 00 s×s, 01 u×u, 10 u×s, 11 as 00 |
| src_a | input | 128 | First matrix, 2 rows of 8 bytes, row-major |
| src_b | input | 128 | Second matrix, 2 columns of 8 bytes, column-major |
| acc_in | input | 128 | Four 32-bit accumulator lanes |
| valid_out | output | 1 | Result on acc_out is new this cycle |
| acc_out | output | 128 | Four 32-bit accumulated lanes, registered |

## Verification
Two things can happen in the same cycle. The output register can present one operation's result while the next operation, possibly in a different mode, is captured, and a mode change can come exactly on that boundary. To provoke this, the bench issues long runs of back-to-back operations with a random mode and random operands on every clock, and mixes these runs with runs that have idle gaps. A behavioural model computes each lane from integer arithmetic on every clock. Both valid_out and each result are compared against the model one cycle after their own issue, so a result that is late, stale or taken from a neighbouring operation shows up as a mismatch.

// File: rtl/mmla_pkg.sv
`timescale 1ns/1ps
package mmla_pkg;

    typedef enum logic [1:0] {
        MODE_SS  = 2'b00,
        MODE_UU  = 2'b01,
        MODE_US  = 2'b10,
        MODE_RSV = 2'b11
    } mmla_mode_t;

    // First operand is read unsigned in the u*u and u*s modes.
    function automatic logic lhs_unsigned(input mmla_mode_t m);
        return (m == MODE_UU) || (m == MODE_US);
    endfunction

    // Second operand is read unsigned only in the u*u mode.
    function automatic logic rhs_unsigned(input mmla_mode_t m);
        return (m == MODE_UU);
    endfunction

endpackage

// File: rtl/mmla_byte_ext.sv
`timescale 1ns/1ps
// Widens every element by one bit: zero fill when unsigned, sign fill otherwise.
module mmla_byte_ext #(
    parameter int EW = 8,
    parameter int N  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N*EW-1:0]     raw,
    input  logic                uns,
    output logic [N*(EW+1)-1:0] ext
);
    localparam int XW = EW + 1;

    for (genvar e = 0; e < N; e++) begin : g_elem
        assign ext[e*XW +: XW] = {(uns ? 1'b0 : raw[e*EW+EW-1]), raw[e*EW +: EW]};

        p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
            uns |-> (ext[e*XW+EW] == 1'b0));
        p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !uns |-> (ext[e*XW+EW] == raw[e*EW+EW-1]));
    end

endmodule

// File: rtl/mmla_dot_lane.sv
`timescale 1ns/1ps
// One output element: K-term dot product of widened elements plus accumulator.
module mmla_dot_lane #(
    parameter int EW    = 8,
    parameter int K     = 8,
    parameter int ACC_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [K*(EW+1)-1:0]   row_v,
    input  logic [K*(EW+1)-1:0]   col_v,
    input  logic [ACC_W-1:0]      acc_v,
    output logic [ACC_W-1:0]      sum_v
);
    localparam int XW = EW + 1;
    localparam int PW = 2 * XW;

    function automatic logic [ACC_W-1:0] dot_acc(
        input logic [K*XW-1:0] av,
        input logic [K*XW-1:0] bv,
        input logic [ACC_W-1:0] base
    );
        logic [ACC_W-1:0]     s;
        logic signed [PW-1:0] p;
        s = base;
        for (int k = 0; k < K; k++) begin
            p = PW'($signed(av[k*XW +: XW])) * PW'($signed(bv[k*XW +: XW]));
            s = s + {{(ACC_W-PW){p[PW-1]}}, p};
        end
        return s;
    endfunction

    assign sum_v = dot_acc(row_v, col_v, acc_v);

    // A zero row contributes nothing: the lane passes its accumulator through.
    p_zero_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_v == '0) |-> (sum_v == acc_v));

endmodule

// File: rtl/byte_mmla2x2.sv
`timescale 1ns/1ps
module byte_mmla2x2
    import mmla_pkg::*;
#(
    parameter int EW    = 8,
    parameter int K     = 8,
    parameter int ROWS  = 2,
    parameter int COLS  = 2,
    parameter int ACC_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_in,
    input  logic [1:0]                  mode,
    input  logic [ROWS*K*EW-1:0]        src_a,
    input  logic [COLS*K*EW-1:0]        src_b,
    input  logic [ROWS*COLS*ACC_W-1:0]  acc_in,
    output logic                        valid_out,
    output logic [ROWS*COLS*ACC_W-1:0]  acc_out
);
    localparam int XW    = EW + 1;
    localparam int NA    = ROWS * K;
    localparam int NB    = COLS * K;
    localparam int LANES = ROWS * COLS;
    localparam int OUT_W = LANES * ACC_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] res;
    } mmla_state_t;

    mmla_state_t st_d, st_q;

    mmla_mode_t        mode_sel;
    logic              a_uns, b_uns;
    logic [NA*XW-1:0]  a_x;
    logic [NB*XW-1:0]  b_x;
    logic [OUT_W-1:0]  lane_sum;

    assign mode_sel = mmla_mode_t'(mode);
    assign a_uns    = lhs_unsigned(mode_sel);
    assign b_uns    = rhs_unsigned(mode_sel);

    mmla_byte_ext #(.EW(EW), .N(NA)) u_ext_a (
        .clk(clk), .rst_n(rst_n), .raw(src_a), .uns(a_uns), .ext(a_x)
    );
    mmla_byte_ext #(.EW(EW), .N(NB)) u_ext_b (
        .clk(clk), .rst_n(rst_n), .raw(src_b), .uns(b_uns), .ext(b_x)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int L = r * COLS + c;
            mmla_dot_lane #(.EW(EW), .K(K), .ACC_W(ACC_W)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .row_v (a_x[r*K*XW +: K*XW]),
                .col_v (b_x[c*K*XW +: K*XW]),
                .acc_v (acc_in[L*ACC_W +: ACC_W]),
                .sum_v (lane_sum[L*ACC_W +: ACC_W])
            );
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (valid_in) begin
            st_d.res = lane_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.vld;
    assign acc_out   = st_q.res;

    p_issue_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_idle_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(acc_out));
    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (acc_out == $past(lane_sum)));

endmodule

// File: tb/byte_mmla2x2_test.sv
`timescale 1ns/1ps
module byte_mmla2x2_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] acc_in = '0;
    logic         valid_out;
    logic [127:0] acc_out;

    int    checks = 0;
    int    errors = 0;
    bit    run_chk = 1'b0;
    bit    done = 1'b0;
    string tag_in = "R1";

    logic         exp_vld = 1'b0;
    logic [127:0] exp_res = '0;
    string        exp_tag = "R1";

    always #2.5 clk = ~clk;

    byte_mmla2x2 uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode(mode),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .valid_out(valid_out), .acc_out(acc_out)
    );

    // Behavioural model: integer arithmetic per lane, wrap by int width.
    function automatic logic [127:0] model(input logic [1:0] m, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] acc);
        logic [127:0] out;
        bit au, bu;
        au = (m == 2'b01) || (m == 2'b10);
        bu = (m == 2'b01);
        out = '0;
        for (int lane = 0; lane < 4; lane++) begin
            int s;
            int row;
            int col;
            row = lane / 2;
            col = lane % 2;
            s = int'(acc[lane*32 +: 32]);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] xa, xb;
                int va, vb;
                xa = a[(row*8+k)*8 +: 8];
                xb = b[(col*8+k)*8 +: 8];
                va = au ? int'(xa) : int'($signed(xa));
                vb = bu ? int'(xb) : int'($signed(xb));
                s = s + va * vb;
            end
            out[lane*32 +: 32] = s;
        end
        return out;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_vld <= 1'b0;
            exp_res <= '0;
        end else begin
            exp_vld <= valid_in;
            if (valid_in) begin
                exp_res <= model(mode, src_a, src_b, acc_in);
                exp_tag <= tag_in;
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    always @(negedge clk) begin
        if (run_chk && !done) begin
            checks++;
            if (valid_out !== exp_vld) begin
                errors++;
                $display("FAIL R2 valid_out act=%0b exp=%0b", valid_out, exp_vld);
            end
            checks++;
            if (acc_out !== exp_res) begin
                errors++;
                $display("FAIL %s acc_out act=%h exp=%h", exp_tag, acc_out, exp_res);
            end
        end
    end

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic issue(input logic [1:0] m, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] acc, input string t);
        @(posedge clk);
        #1;
        valid_in = 1'b1;
        mode     = m;
        src_a    = a;
        src_b    = b;
        acc_in   = acc;
        tag_in   = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            valid_in = 1'b0;
            src_a    = rnd128();
            src_b    = rnd128();
            acc_in   = rnd128();
            mode     = 2'($urandom());
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [127:0] a_rows;
        logic [127:0] b_cols;
        logic [127:0] acc_lanes;
        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        checks++;
        if (valid_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 valid_out act=%0b exp=0", valid_out);
        end
        checks++;
        if (acc_out !== '0) begin
            errors++;
            $display("FAIL R1 acc_out act=%h exp=0", acc_out);
        end
        #1;
        rst_n = 1'b1;
        run_chk = 1'b1;
        idle(2);

        // R3: lane placement, distinct rows and one-hot columns
        for (int i = 0; i < 16; i++) a_rows[i*8 +: 8] = 8'(i + 1);
        b_cols = '0;
        b_cols[0*8 +: 8] = 8'd1;
        b_cols[15*8 +: 8] = 8'd1;
        acc_lanes = {32'd4000, 32'd3000, 32'd2000, 32'd1000};
        issue(2'b00, a_rows, b_cols, acc_lanes, "R3");
        issue(2'b01, a_rows, rnd128(), acc_lanes, "R3");
        idle(1);

        // R4..R7: all-ones and most-negative byte patterns in every mode
        issue(2'b00, {16{8'hFF}}, {16{8'hFF}}, '0, "R4");
        issue(2'b01, {16{8'hFF}}, {16{8'hFF}}, '0, "R5");
        issue(2'b10, {16{8'hFF}}, {16{8'hFF}}, '0, "R6");
        issue(2'b11, {16{8'hFF}}, {16{8'hFF}}, '0, "R7");
        issue(2'b00, {16{8'h80}}, {16{8'h80}}, rnd128(), "R4");
        issue(2'b01, {16{8'h80}}, {16{8'h80}}, rnd128(), "R5");
        issue(2'b10, {16{8'h80}}, {16{8'h80}}, rnd128(), "R6");
        issue(2'b11, {16{8'h80}}, {16{8'h7F}}, rnd128(), "R7");
        issue(2'b10, {16{8'h80}}, {16{8'h7F}}, rnd128(), "R6");
        idle(1);

        // R8: wrap in both directions
        issue(2'b01, {16{8'hFF}}, {16{8'hFF}}, {4{32'h7FFF_FFFF}}, "R8");
        issue(2'b00, {16{8'h80}}, {16{8'h7F}}, {4{32'h8000_0000}}, "R8");
        issue(2'b01, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, "R8");

        // R9: idle edges with noisy inputs must not disturb the output
        idle(4);

        // R10: back-to-back issues with a random mode every clock
        for (int i = 0; i < 60; i++) begin
            issue(2'($urandom()), rnd128(), rnd128(), rnd128(), "R10");
        end
        // Random modes with idle gaps
        for (int i = 0; i < 40; i++) begin
            logic [1:0] m;
            m = 2'($urandom());
            issue(m, rnd128(), rnd128(), rnd128(),
                  (m == 2'b00) ? "R4" : (m == 2'b01) ? "R5" : (m == 2'b10) ? "R6" : "R7");
            idle(int'($urandom_range(0, 2)));
        end
        idle(3);
        @(posedge clk);
        #1;
        finish_run();
    end

endmodule